// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each of its entries records a virtual page number, the physical page it maps to, three permission bits, two cache attribute bits, an 8-bit address-space tag and a global flag. The lookup port compares a virtual page and the current address-space tag against every entry in parallel. In the same cycle, from registered state, it reports a hit together with that entry's physical page, permissions and attributes.

A fill port writes the result of a page walk. The new entry goes into the lowest-numbered free slot. When no slot is free, a round-robin pointer picks the victim and skips entries that are pinned. A maintenance port offers four operations: flush everything, drop one virtual page, drop one address space, and pin the entry that would hit. Entries from several address spaces can stay resident at the same time. A lookup simply ignores entries whose tag does not match.

Top module: `xlt_tlb`

## Requirements
- R1: After reset every entry is empty: every lookup misses, outputs read zero and `fill_ovf` is low.
- R2: A lookup hits when a valid entry holds `lk_vpn` and either its tag equals `lk_asid` or its global flag is set. `lk_ppn`, `lk_perm` and `lk_attr` then show that entry's fields in the same cycle. On a miss all three read zero.
- R3: A non-global entry whose tag differs from `lk_asid` does not hit, but it stays resident and still hits under its own tag.
- R4: A fill with `fill_en` high and `mnt_en` low is visible to lookups after the next rising edge. It goes into the lowest-numbered empty entry whenever one exists.
- R5: When every entry is valid, a fill replaces the entry at the round-robin pointer, or the next unpinned entry after it, counting upward and wrapping. The pointer is 0 after reset and moves to the replaced index plus one (wrapping) after each such replacement. A pinned entry is never replaced.
- R6: When all entries are pinned, a fill is dropped and `fill_ovf` is high for exactly the one cycle after that edge. The contents stay unchanged.
- R7: Maintenance code 0 (flush) clears every entry, including pinned ones.
- R8: Maintenance code 1 clears every entry whose virtual page equals `mnt_vpn`, whatever its tag or pin state.
- R9: Maintenance code 2 clears the non-global entries whose tag equals `mnt_asid`. Global entries and other tags are kept.
- R10: Maintenance code 3 pins every entry that a lookup of `mnt_vpn` and `mnt_asid` would hit. A fill with `fill_lock` high writes an entry that is already pinned.
- R11: While `mnt_en` is high, `fill_en` is ignored: nothing is written and `fill_ovf` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page of the hit entry |
| lk_perm | output | 3 | Permission bits of the hit entry |
| lk_attr | output | 2 | Cache attribute bits of the hit entry |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_asid | input | 8 | Tag of the new entry |
| fill_global | input | 1 | New entry matches any tag |
| fill_ppn | input | 20 | Physical page of the new entry |
| fill_perm | input | 3 | Permission bits of the new entry |
| fill_attr | input | 2 | Attribute bits of the new entry |
| fill_lock | input | 1 | Pin the new entry |
| fill_ovf | output | 1 | A fill was dropped because all entries are pinned |
| mnt_en | input | 1 | Run a maintenance operation |
| mnt_op | input | 2 | 0 flush, 1 drop page, 2 drop tag, 3 pin |
| mnt_vpn | input | 20 | Page operand for codes 1 and 3 |
| mnt_asid | input | 8 | Tag operand for codes 2 and 3 |

## Verification
The assertion that at most one entry matches a lookup depends on the caller never filling a page and tag pair that already hits. The fill port does not check for duplicates. The stimulus respects this: before a page is refilled it is first dropped, flushed or evicted, and distinct pages or distinct non-global tags are used everywhere else. The checks on held pinned entries also assume that only maintenance can remove a pinned entry. The stimulus never relies on a fill displacing one.

// File: rtl/xlt_tlb_pkg.sv
package xlt_tlb_pkg;
  typedef enum logic [1:0] {
    MNT_FLUSH    = 2'd0,
    MNT_DROP_VPN = 2'd1,
    MNT_DROP_TAG = 2'd2,
    MNT_PIN      = 2'd3
  } mnt_op_e;
endpackage

// File: rtl/xlt_tlb_match.sv
module xlt_tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             glob,
  input  logic [N-1:0][VPN_W-1:0]  vpn_tags,
  input  logic [N-1:0][ASID_W-1:0] asid_tags,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             vpn_eq,
  output logic [N-1:0]             hit
);
  // one comparator pair per entry, all in parallel
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign vpn_eq[i] = valid[i] && (vpn_tags[i] == q_vpn);
    assign hit[i]    = vpn_eq[i] && (glob[i] || (asid_tags[i] == q_asid));
  end
endmodule

// File: rtl/xlt_tlb_victim.sv
module xlt_tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     lock,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic             has_victim,
  output logic [IDX_W-1:0] victim_idx,
  output logic             used_rr
);
  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic             any_unpinned;
  logic [IDX_W-1:0] rr_idx;

  // lowest empty slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // first unpinned slot at or after the pointer, wrapping
  always_comb begin
    any_unpinned = 1'b0;
    rr_idx       = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(rr_ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!lock[idx]) begin
        any_unpinned = 1'b1;
        rr_idx       = IDX_W'(idx);
      end
    end
  end

  assign has_victim = any_free || any_unpinned;
  assign used_rr    = !any_free && any_unpinned;
  assign victim_idx = any_free ? free_idx : rr_idx;

  // R5: the chosen victim is never a pinned entry
  p_victim_unpinned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    has_victim |-> !lock[victim_idx]);
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3,
  parameter int ATTR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              fill_lock,
  output logic              fill_ovf,
  input  logic              mnt_en,
  input  logic [1:0]        mnt_op,
  input  logic [VPN_W-1:0]  mnt_vpn,
  input  logic [ASID_W-1:0] mnt_asid
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]             valid_q, valid_d;
  logic [N-1:0]             lock_q,  lock_d;
  logic [N-1:0]             glob_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;
  logic [N-1:0][ATTR_W-1:0] attr_q;
  logic [IDX_W-1:0]         rr_q, rr_d;
  logic                     ovf_q, ovf_d;
  logic [N-1:0]             wr_en;

  logic [N-1:0] lk_hitv, lk_vpn_eq_unused;
  logic [N-1:0] m_hitv, m_vpn_eq;
  logic             has_victim, used_rr;
  logic [IDX_W-1:0] victim_idx;
  logic             fill_go;
  mnt_op_e          op;

  xlt_tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(valid_q), .glob(glob_q), .vpn_tags(vpn_q), .asid_tags(asid_q),
    .q_vpn(lk_vpn), .q_asid(lk_asid), .vpn_eq(lk_vpn_eq_unused), .hit(lk_hitv));

  xlt_tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_mnt_match (
    .valid(valid_q), .glob(glob_q), .vpn_tags(vpn_q), .asid_tags(asid_q),
    .q_vpn(mnt_vpn), .q_asid(mnt_asid), .vpn_eq(m_vpn_eq), .hit(m_hitv));

  xlt_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .lock(lock_q), .rr_ptr(rr_q),
    .has_victim(has_victim), .victim_idx(victim_idx), .used_rr(used_rr));

  // lookup read mux: AND-OR over the hit vector, zero on miss
  always_comb begin
    lk_hit  = |lk_hitv;
    lk_ppn  = '0;
    lk_perm = '0;
    lk_attr = '0;
    for (int i = 0; i < N; i++) begin
      lk_ppn  = lk_ppn  | (ppn_q[i]  & {PPN_W{lk_hitv[i]}});
      lk_perm = lk_perm | (perm_q[i] & {PERM_W{lk_hitv[i]}});
      lk_attr = lk_attr | (attr_q[i] & {ATTR_W{lk_hitv[i]}});
    end
  end

  assign op      = mnt_op_e'(mnt_op);
  assign fill_go = fill_en && !mnt_en;

  // next state: maintenance first, fill only when no maintenance
  always_comb begin
    valid_d = valid_q;
    lock_d  = lock_q;
    rr_d    = rr_q;
    ovf_d   = 1'b0;
    wr_en   = '0;
    if (mnt_en) begin
      unique case (op)
        MNT_FLUSH: begin
          valid_d = '0;
          lock_d  = '0;
        end
        MNT_DROP_VPN: begin
          valid_d = valid_q & ~m_vpn_eq;
          lock_d  = lock_q  & ~m_vpn_eq;
        end
        MNT_DROP_TAG: begin
          for (int i = 0; i < N; i++) begin
            if (!glob_q[i] && (asid_q[i] == mnt_asid)) begin
              valid_d[i] = 1'b0;
              lock_d[i]  = 1'b0;
            end
          end
        end
        MNT_PIN: lock_d = lock_q | m_hitv;
        default: ;
      endcase
    end else if (fill_en) begin
      if (has_victim) begin
        wr_en[victim_idx]   = 1'b1;
        valid_d[victim_idx] = 1'b1;
        lock_d[victim_idx]  = fill_lock;
        if (used_rr) begin
          rr_d = (int'(victim_idx) == N - 1) ? '0 : victim_idx + 1'b1;
        end
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      rr_q    <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
      rr_q    <= rr_d;
      ovf_q   <= ovf_d;
    end
  end

  // payload storage: no reset, written under a per-entry clock enable
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en[i]) begin
        vpn_q[i]  <= fill_vpn;
        asid_q[i] <= fill_asid;
        glob_q[i] <= fill_global;
        ppn_q[i]  <= fill_ppn;
        perm_q[i] <= fill_perm;
        attr_q[i] <= fill_attr;
      end
    end

    // R5: a pinned entry survives any cycle without maintenance
    p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[i] && !mnt_en) |=> (valid_q[i] && lock_q[i] && $stable(vpn_q[i])));
  end

  assign fill_ovf = ovf_q;

  // R2: under the no-duplicate input rule at most one entry hits
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv));
  // R6: a fill against a fully pinned buffer raises the flag
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && (&lock_q)) |=> fill_ovf);
  // R11: no flag without an accepted fill request
  p_ovf_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_go |=> !fill_ovf);
  // R7: flush leaves nothing valid or pinned
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_en && mnt_op == 2'd0) |=> (valid_q == '0 && lock_q == '0));
  // R10: pin only marks valid entries
  p_pin_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~valid_q) == '0);
endmodule

// File: tb/xlt_tlb_tb_top.sv
`timescale 1ns/1ps
module xlt_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [2:0]  lk_perm;
  logic [1:0]  lk_attr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic        fill_global = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic [1:0]  fill_attr = '0;
  logic        fill_lock = 1'b0;
  logic        fill_ovf;
  logic        mnt_en = 1'b0;
  logic [1:0]  mnt_op = '0;
  logic [19:0] mnt_vpn = '0;
  logic [7:0]  mnt_asid = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  xlt_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_attr(lk_attr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_global(fill_global), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .fill_attr(fill_attr), .fill_lock(fill_lock), .fill_ovf(fill_ovf),
    .mnt_en(mnt_en), .mnt_op(mnt_op), .mnt_vpn(mnt_vpn), .mnt_asid(mnt_asid));

  // vector kinds: 0 fill, 1 lookup check, 2 maintenance (op field)
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        glob;
    logic [19:0] ppn;
    logic        hit;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 20'h00401, 8'h05, 1'b0, 20'h80010, 1'b0},
    '{2'd0, 2'd0, 20'h00401, 8'h07, 1'b0, 20'h12345, 1'b0},
    '{2'd0, 2'd0, 20'h00ABC, 8'h01, 1'b1, 20'h0BEEF, 1'b0},
    '{2'd1, 2'd0, 20'h00401, 8'h05, 1'b0, 20'h80010, 1'b1},  // R2
    '{2'd1, 2'd0, 20'h00401, 8'h07, 1'b0, 20'h12345, 1'b1},  // R3 coexist
    '{2'd1, 2'd0, 20'h00401, 8'h09, 1'b0, 20'h00000, 1'b0},  // R3 other tag
    '{2'd1, 2'd0, 20'h00ABC, 8'h03, 1'b0, 20'h0BEEF, 1'b1},  // R2 global
    '{2'd1, 2'd0, 20'h00402, 8'h05, 1'b0, 20'h00000, 1'b0},  // R2 miss
    '{2'd2, 2'd2, 20'h00000, 8'h05, 1'b0, 20'h00000, 1'b0},  // drop tag 5
    '{2'd1, 2'd0, 20'h00401, 8'h05, 1'b0, 20'h00000, 1'b0},  // R9
    '{2'd1, 2'd0, 20'h00401, 8'h07, 1'b0, 20'h12345, 1'b1},  // R9 other kept
    '{2'd2, 2'd2, 20'h00000, 8'h01, 1'b0, 20'h00000, 1'b0},  // drop tag 1
    '{2'd1, 2'd0, 20'h00ABC, 8'h01, 1'b0, 20'h0BEEF, 1'b1},  // R9 global kept
    '{2'd2, 2'd1, 20'h00401, 8'h00, 1'b0, 20'h00000, 1'b0},  // drop page
    '{2'd1, 2'd0, 20'h00401, 8'h07, 1'b0, 20'h00000, 1'b0},  // R8
    '{2'd1, 2'd0, 20'h00ABC, 8'h02, 1'b0, 20'h0BEEF, 1'b1},  // R8 others kept
    '{2'd1, 2'd0, 20'h00ABC, 8'h01, 1'b0, 20'h0BEEF, 1'b1}   // R8
  };

  task automatic do_fill(input logic [19:0] v, input logic [7:0] a,
                         input logic g, input logic [19:0] p, input logic lk,
                         input logic with_mnt);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_asid = a; fill_global = g;
    fill_ppn = p; fill_perm = p[2:0]; fill_attr = p[4:3]; fill_lock = lk;
    if (with_mnt) begin
      mnt_en = 1'b1; mnt_op = 2'd2; mnt_asid = 8'hEE;
    end
    @(negedge clk);
    fill_en = 1'b0; fill_lock = 1'b0; mnt_en = 1'b0;
  endtask

  task automatic do_mnt(input logic [1:0] o, input logic [19:0] v,
                        input logic [7:0] a);
    @(negedge clk);
    mnt_en = 1'b1; mnt_op = o; mnt_vpn = v; mnt_asid = a;
    @(negedge clk);
    mnt_en = 1'b0;
  endtask

  task automatic chk(input logic [19:0] v, input logic [7:0] a,
                     input logic eh, input logic [19:0] ep, input string r);
    logic [2:0] xp;
    logic [1:0] xa;
    lk_vpn = v; lk_asid = a;
    #1;
    xp = eh ? ep[2:0] : 3'd0;
    xa = eh ? ep[4:3] : 2'd0;
    total++;
    if (lk_hit !== eh || lk_ppn !== (eh ? ep : 20'h0) ||
        lk_perm !== xp || lk_attr !== xa) begin
      bad++;
      $display("FAIL %s vpn=%h asid=%h: hit=%b ppn=%h perm=%h attr=%h expected hit=%b ppn=%h perm=%h attr=%h",
               r, v, a, lk_hit, lk_ppn, lk_perm, lk_attr, eh, eh ? ep : 20'h0, xp, xa);
    end
  endtask

  task automatic chk_ovf(input logic e, input string r);
    total++;
    if (fill_ovf !== e) begin
      bad++;
      $display("FAIL %s fill_ovf=%b expected %b", r, fill_ovf, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(20'h00401, 8'h05, 1'b0, 20'h0, "R1 reset miss");
    chk_ovf(1'b0, "R1 reset flag");
    rst_n = 1'b1;
    @(negedge clk);
    chk(20'h00000, 8'h00, 1'b0, 20'h0, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        2'd0: do_fill(VECS[i].vpn, VECS[i].asid, VECS[i].glob, VECS[i].ppn, 1'b0, 1'b0);
        2'd1: chk(VECS[i].vpn, VECS[i].asid, VECS[i].hit, VECS[i].ppn, "table");
        default: do_mnt(VECS[i].op, VECS[i].vpn, VECS[i].asid);
      endcase
    end

    // R7: flush
    do_mnt(2'd0, 20'h0, 8'h0);
    chk(20'h00ABC, 8'h01, 1'b0, 20'h0, "R7 flush global");

    // R4: fill visible next cycle, fills all slots in order
    for (int i = 0; i < 16; i++)
      do_fill(20'h00100 + 20'(i), 8'h01, 1'b0, 20'h00200 + 20'(i), 1'b0, 1'b0);
    chk(20'h00100, 8'h01, 1'b1, 20'h00200, "R4 first");
    chk(20'h0010F, 8'h01, 1'b1, 20'h0020F, "R4 last");

    // R5: round robin from 0
    do_fill(20'h00300, 8'h01, 1'b0, 20'h00A00, 1'b0, 1'b0);
    chk(20'h00100, 8'h01, 1'b0, 20'h0, "R5 slot0 evicted");
    chk(20'h00300, 8'h01, 1'b1, 20'h00A00, "R5 new entry");
    chk(20'h00101, 8'h01, 1'b1, 20'h00201, "R5 slot1 kept");
    do_fill(20'h00301, 8'h01, 1'b0, 20'h00A01, 1'b0, 1'b0);
    chk(20'h00101, 8'h01, 1'b0, 20'h0, "R5 slot1 evicted");

    // R4: freed slot 5 is used before the pointer
    do_mnt(2'd1, 20'h00105, 8'h0);
    do_fill(20'h00302, 8'h01, 1'b0, 20'h00A02, 1'b0, 1'b0);
    chk(20'h00102, 8'h01, 1'b1, 20'h00202, "R4 free slot preferred");
    do_fill(20'h00303, 8'h01, 1'b0, 20'h00A03, 1'b0, 1'b0);
    chk(20'h00102, 8'h01, 1'b0, 20'h0, "R5 slot2 evicted");
    chk(20'h00302, 8'h01, 1'b1, 20'h00A02, "R4 refilled slot5 kept");

    // R10 + R5: pin slot3, pointer skips it
    do_mnt(2'd3, 20'h00103, 8'h01);
    do_fill(20'h00304, 8'h01, 1'b0, 20'h00A04, 1'b0, 1'b0);
    chk(20'h00103, 8'h01, 1'b1, 20'h00203, "R10 pinned kept");
    chk(20'h00104, 8'h01, 1'b0, 20'h0, "R5 skip to slot4");

    // R11: fill ignored during maintenance
    do_fill(20'h00305, 8'h01, 1'b0, 20'h00A05, 1'b0, 1'b1);
    chk(20'h00305, 8'h01, 1'b0, 20'h0, "R11 fill ignored");
    chk_ovf(1'b0, "R11 no flag");

    // R6: all pinned
    do_mnt(2'd0, 20'h0, 8'h0);
    for (int i = 0; i < 16; i++)
      do_fill(20'h00400 + 20'(i), 8'h02, 1'b0, 20'h00500 + 20'(i), 1'b1, 1'b0);
    chk_ovf(1'b0, "R6 no flag while space");
    do_fill(20'h00600, 8'h02, 1'b0, 20'h00700, 1'b0, 1'b0);
    chk_ovf(1'b1, "R6 flag raised");
    chk(20'h00600, 8'h02, 1'b0, 20'h0, "R6 dropped fill");
    chk(20'h00400, 8'h02, 1'b1, 20'h00500, "R6 contents kept");
    @(negedge clk);
    chk_ovf(1'b0, "R6 one cycle only");

    // R8: dropping a page clears a pinned entry, slot reusable
    do_mnt(2'd1, 20'h00407, 8'h0);
    chk(20'h00407, 8'h02, 1'b0, 20'h0, "R8 pinned dropped");
    do_fill(20'h00600, 8'h02, 1'b0, 20'h00700, 1'b0, 1'b0);
    chk(20'h00600, 8'h02, 1'b1, 20'h00700, "R8 slot reused");
    chk_ovf(1'b0, "R8 no flag");

    // R7: flush clears pins too
    do_mnt(2'd0, 20'h0, 8'h0);
    do_fill(20'h00800, 8'h03, 1'b0, 20'h00900, 1'b0, 1'b0);
    chk(20'h00800, 8'h03, 1'b1, 20'h00900, "R7 pins gone");
    chk(20'h00400, 8'h02, 1'b0, 20'h0, "R7 old entry gone");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule